// File: doc/BRIEF.md
# SPI Frame-Count Transfer Sequencer

This block is an SPI master engine that empties a transmit queue one frame at a time. For each word it takes, it drives the word out on MOSI, most significant bit first, and captures the same number of bits from MISO. The captured word is then pushed into a receive queue. The frame width is programmable from 1 to 32 bits. SCLK comes from a simple divider on the system clock. The block drives one active-low chip select.

A transaction is a programmed number of frames. A hold-select control bit picks between two chip-select behaviours: select stays low across the whole transaction, or it is released for at least one SCLK period after every frame. When the last frame of a transaction completes, the block releases chip select, sets its transfer-done and receive-ready flags, and reloads the frame counter for the next transaction. A soft reset carried on the control write restores every setting to its default.

Top module: `spi_frame_seq`

## Requirements
- R1: A frame starts only when the block is enabled, `tx_valid` is high and the remaining frame count is nonzero; otherwise `tx_pop` stays low and `cs_n` stays high.
- R2: Each frame shifts exactly `size` bits in SPI mode 0. MOSI is sent MSB first from the low `size` bits of the queued word and changes only on SCLK falling edges. MISO is sampled on rising edges, and the result appears right-aligned on `rx_data`, with zeros above bit `size`-1.
- R3: A `size_we` write is accepted only with a value from 1 to 32 and only while the block is disabled. A value of 0, a value above 32, or any write while enabled leaves the frame size unchanged.
- R4: The remaining frame count is loaded from `ctrl_frames` on every control write and reloaded from the stored value when a transaction completes. A transaction therefore consists of exactly that many frames.
- R5: With `ctrl_hold_cs` set, `cs_n` stays low from the first frame to the last frame of a transaction and rises once. With it clear, `cs_n` rises after every frame and stays high for at least 2*(div+1) cycles before the next frame.
- R6: When the last frame of a transaction ends, `cs_n` goes high, `xfer_done` and `rx_ready` are set, and `done_pulse` is high for one cycle.
- R7: `xfer_done` and `rx_ready` are cleared in the same cycle that chip select falls for a new frame.
- R8: If `rx_full` is high when a frame ends, `rx_push` stays low and `ovf_pulse` is high for one cycle in its place.
- R9: Each SCLK half period lasts div+1 system clocks, counted from the frame start. SCLK is low whenever `cs_n` is high.
- R10: A reset, or a control write with `ctrl_soft_rst` set, restores the defaults: frame size 4, divider 7, disabled, hold clear, frame count 1, `cs_n` high and both flags clear.
- R11: `tx_pop` is a single-cycle acknowledge that the word on `tx_data` was taken. It is issued once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_enable | input | 1 | Enable value for a control write |
| ctrl_hold_cs | input | 1 | Hold chip select across a transaction |
| ctrl_soft_rst | input | 1 | Soft reset qualifier for a control write |
| ctrl_frames | input | 16 | Frames per transaction |
| size_we | input | 1 | Frame size write strobe |
| size_val | input | 6 | Frame size in bits |
| div_we | input | 1 | Divider write strobe |
| div_val | input | 8 | Divider value N, SCLK = clk / (2*(N+1)) |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Head word of the transmit queue |
| tx_pop | output | 1 | Head word taken |
| rx_full | input | 1 | Receive queue has no room |
| rx_push | output | 1 | Write `rx_data` into the receive queue |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| xfer_done | output | 1 | Transfer-done flag |
| rx_ready | output | 1 | Receive-ready flag |
| done_pulse | output | 1 | One-cycle transaction-complete pulse |
| ovf_pulse | output | 1 | One-cycle receive overflow pulse |

## Verification
Random transactions mix frame widths from 1 to 32, dividers from 0 to 3, one to five frames and both select modes. A serial slave model compares every MOSI bit with the queued word and returns known MISO words, so any bit-order, width or alignment fault shows as a data mismatch. The cycle gaps between SCLK edges and the number of chip-select rises are measured separately in each mode, which exposes timing and mode faults even when the data is correct. Directed runs cover a disabled block, a zero frame count, rejected size writes, a full receive queue and a soft reset, which checks that the default size and divider take effect again.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/spi_seq_cfg.sv
// Configuration holding registers with write-acceptance rules.
module spi_seq_cfg #(
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 6,
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 16,
  parameter int DEF_SIZE = 4,
  parameter int DEF_DIV  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ctrl_we,
  input  logic              ctrl_enable,
  input  logic              ctrl_hold_cs,
  input  logic [CNT_W-1:0]  ctrl_frames,
  input  logic              size_we,
  input  logic [SIZE_W-1:0] size_val,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_val,
  output logic              en,
  output logic              hold,
  output logic [CNT_W-1:0]  frames,
  output logic [SIZE_W-1:0] size,
  output logic [DIV_W-1:0]  div
);
  localparam logic [SIZE_W-1:0] MAX_SIZE = SIZE_W'(DATA_W);

  logic size_ok;
  assign size_ok = size_we && !en && (size_val != '0) && (size_val <= MAX_SIZE);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      en     <= 1'b0;
      hold   <= 1'b0;
      frames <= CNT_W'(1);
      size   <= SIZE_W'(DEF_SIZE);
      div    <= DIV_W'(DEF_DIV);
    end else begin
      if (ctrl_we) begin
        en     <= ctrl_enable;
        hold   <= ctrl_hold_cs;
        frames <= ctrl_frames;
      end
      if (size_ok) size <= size_val;
      if (div_we)  div  <= div_val;
    end
  end
endmodule

// File: rtl/spi_seq_clkdiv.sv
// Half-period tick generator; clr realigns the phase.
module spi_seq_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_seq_shift.sv
// Mode-0 frame shifter: rise samples MISO, fall advances MOSI.
module spi_seq_shift #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic [SIZE_W-1:0] size,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              fin,
  output logic [DATA_W-1:0] rx_word
);
  logic              busy;
  logic [DATA_W-1:0] shreg;
  logic [SIZE_W-1:0] bitcnt;

  assign mosi = shreg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      shreg   <= '0;
      rx_word <= '0;
      bitcnt  <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        busy    <= 1'b1;
        sclk    <= 1'b0;
        shreg   <= load_word << (DATA_W - int'(size));
        rx_word <= '0;
        bitcnt  <= '0;
      end else if (busy && tick) begin
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_word <= {rx_word[DATA_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitcnt == size - 1'b1) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            shreg  <= shreg << 1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = $clog2(DATA_W + 1),
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 16,
  parameter int DEF_SIZE = 4,
  parameter int DEF_DIV  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              ctrl_enable,
  input  logic              ctrl_hold_cs,
  input  logic              ctrl_soft_rst,
  input  logic [CNT_W-1:0]  ctrl_frames,
  input  logic              size_we,
  input  logic [SIZE_W-1:0] size_val,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              xfer_done,
  output logic              rx_ready,
  output logic              done_pulse,
  output logic              ovf_pulse
);
  logic              soft_rst, rst_all;
  logic              cfg_en, cfg_hold;
  logic [CNT_W-1:0]  cfg_frames;
  logic [SIZE_W-1:0] cfg_size;
  logic [DIV_W-1:0]  cfg_div;
  logic              tick, fin, start, last, enter_gap;
  logic [DATA_W-1:0] rx_word;
  logic [CNT_W-1:0]  remaining;
  logic              gap_half;
  seq_state_t        state;

  assign soft_rst = ctrl_we && ctrl_soft_rst;
  assign rst_all  = rst || soft_rst;

  spi_seq_cfg #(
    .DATA_W(DATA_W), .SIZE_W(SIZE_W), .DIV_W(DIV_W), .CNT_W(CNT_W),
    .DEF_SIZE(DEF_SIZE), .DEF_DIV(DEF_DIV)
  ) u_cfg (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable), .ctrl_hold_cs(ctrl_hold_cs),
    .ctrl_frames(ctrl_frames), .size_we(size_we), .size_val(size_val),
    .div_we(div_we), .div_val(div_val),
    .en(cfg_en), .hold(cfg_hold), .frames(cfg_frames), .size(cfg_size), .div(cfg_div)
  );

  assign start     = (state == ST_IDLE) && cfg_en && tx_valid && (remaining != '0);
  assign last      = (remaining <= CNT_W'(1));
  assign enter_gap = (state == ST_SHIFT) && fin && (last || !cfg_hold);

  spi_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst_all), .clr(start || enter_gap), .div(cfg_div), .tick(tick)
  );

  spi_seq_shift #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_shift (
    .clk(clk), .rst(rst_all), .load(start), .load_word(tx_data), .size(cfg_size),
    .tick(tick), .miso(miso), .sclk(sclk), .mosi(mosi), .fin(fin), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst_all) begin
      state      <= ST_IDLE;
      remaining  <= CNT_W'(1);
      cs_n       <= 1'b1;
      tx_pop     <= 1'b0;
      rx_push    <= 1'b0;
      rx_data    <= '0;
      ovf_pulse  <= 1'b0;
      done_pulse <= 1'b0;
      xfer_done  <= 1'b0;
      rx_ready   <= 1'b0;
      gap_half   <= 1'b0;
    end else begin
      tx_pop     <= 1'b0;
      rx_push    <= 1'b0;
      ovf_pulse  <= 1'b0;
      done_pulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            tx_pop    <= 1'b1;
            cs_n      <= 1'b0;
            xfer_done <= 1'b0;
            rx_ready  <= 1'b0;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (fin) begin
            if (rx_full) begin
              ovf_pulse <= 1'b1;
            end else begin
              rx_push <= 1'b1;
              rx_data <= rx_word;
            end
            remaining <= remaining - 1'b1;
            if (last) begin
              done_pulse <= 1'b1;
              xfer_done  <= 1'b1;
              rx_ready   <= 1'b1;
              remaining  <= cfg_frames;
            end
            if (enter_gap) begin
              cs_n     <= 1'b1;
              gap_half <= 1'b0;
              state    <= ST_GAP;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) state <= ST_IDLE;
            gap_half <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (ctrl_we) remaining <= ctrl_frames;
    end
  end
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk #(
  parameter int SIZE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              cs_n,
  input logic              tx_valid,
  input logic              tx_pop,
  input logic              rx_full,
  input logic              rx_push,
  input logic              ovf_pulse,
  input logic              done_pulse,
  input logic              xfer_done,
  input logic              rx_ready,
  input logic              cfg_en,
  input logic [SIZE_W-1:0] cfg_size,
  input logic              soft_rst
);
  p_sclk_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  p_done_frees_cs_r6: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (cs_n && xfer_done && rx_ready));

  p_flags_clear_at_start_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (!xfer_done && !rx_ready));

  p_no_overflow_push_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (!rx_push && $past(rx_full)));

  p_pop_qualified_r1: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> ($past(tx_valid) && $past(cfg_en)));

  p_pop_single_r11: assert property (@(posedge clk) disable iff (rst)
    tx_pop |=> !tx_pop);

  p_size_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_en) && !$past(soft_rst)) |-> $stable(cfg_size));
endmodule

bind spi_frame_seq spi_frame_seq_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .tx_valid(tx_valid),
  .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .ovf_pulse(ovf_pulse),
  .done_pulse(done_pulse), .xfer_done(xfer_done), .rx_ready(rx_ready),
  .cfg_en(cfg_en), .cfg_size(cfg_size), .soft_rst(soft_rst)
);

// File: tb/spi_frame_seq_tb.sv
`timescale 1ns/1ps
module spi_frame_seq_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic ctrl_we = 0, ctrl_enable = 0, ctrl_hold_cs = 0, ctrl_soft_rst = 0;
  logic [15:0] ctrl_frames = 0;
  logic size_we = 0, div_we = 0;
  logic [5:0] size_val = 0;
  logic [7:0] div_val = 0;
  logic tx_valid, tx_pop, rx_full = 0, rx_push, sclk, mosi, miso = 0, cs_n;
  logic [31:0] tx_data, rx_data;
  logic xfer_done, rx_ready, done_pulse, ovf_pulse;

  always #5 clk = ~clk;

  spi_frame_seq u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable),
    .ctrl_hold_cs(ctrl_hold_cs), .ctrl_soft_rst(ctrl_soft_rst), .ctrl_frames(ctrl_frames),
    .size_we(size_we), .size_val(size_val), .div_we(div_we), .div_val(div_val),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full),
    .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .xfer_done(xfer_done), .rx_ready(rx_ready),
    .done_pulse(done_pulse), .ovf_pulse(ovf_pulse)
  );

  int vectors = 0, errors = 0;
  logic [31:0] txw [64];
  int tx_n = 0, tx_i = 0;
  assign tx_valid = (tx_i < tx_n);
  assign tx_data  = txw[tx_i[5:0]];

  // monitor state
  int exp_size = 4;
  int fi = 0, bi = 0;
  logic [31:0] sin = 0;
  logic [31:0] cap [64];
  logic [31:0] rxq [64];
  int cyc = 0, ref_c = 0, pops = 0, rises = 0, rxn = 0, ovfn = 0, donen = 0;
  int hmin = 0, hmax = 0, gapmin = 0, hi_start = 0, bad_clear = 0;

  function automatic logic [31:0] sword(int i);
    return ((32'(i) + 32'd1) * 32'h9E3779B9) ^ 32'h5A17C3E1;
  endfunction

  function automatic logic [31:0] msk(logic [31:0] w, int sz);
    if (sz >= 32) return w;
    return w & ((32'd1 << sz) - 32'd1);
  endfunction

  function automatic logic sbit(int f, int b);
    logic [31:0] w;
    w = sword(f) >> (exp_size - 1 - b);
    return w[0];
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ge(string req, int act, int lim);
    vectors++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  // SPI slave model
  initial begin
    logic ps, pc;
    ps = 1'b0; pc = 1'b1;
    forever begin
      @(posedge sclk or negedge sclk or negedge cs_n or posedge cs_n);
      if (cs_n === 1'b0 && pc === 1'b1 && bi == 0) miso = sbit(fi, 0);
      if (sclk === 1'b1 && ps === 1'b0) begin
        sin = {sin[30:0], mosi};
        bi++;
      end
      if (sclk === 1'b0 && ps === 1'b1) begin
        if (bi == exp_size) begin
          cap[fi[5:0]] = sin;
          fi++; bi = 0; sin = 0;
        end
        miso = sbit(fi, bi);
      end
      ps = sclk; pc = cs_n;
    end
  end

  // cycle monitor, sampled away from the active edge
  initial begin
    logic ms, mc;
    ms = 1'b0; mc = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (tx_pop) begin
        ref_c = cyc; pops++; tx_i++;
        if (xfer_done || rx_ready) bad_clear++;
      end
      if (sclk !== ms) begin
        if (cyc - ref_c < hmin) hmin = cyc - ref_c;
        if (cyc - ref_c > hmax) hmax = cyc - ref_c;
        ref_c = cyc;
      end
      if (cs_n && !mc) begin rises++; hi_start = cyc; end
      if (!cs_n && mc && (cyc - hi_start < gapmin)) gapmin = cyc - hi_start;
      if (rx_push) begin rxq[rxn[5:0]] = rx_data; rxn++; end
      if (ovf_pulse) ovfn++;
      if (done_pulse) donen++;
      ms = sclk; mc = cs_n;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; vectors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic do_ctrl(bit en, bit hold, int frames, bit srst);
    @(negedge clk);
    ctrl_we = 1; ctrl_enable = en; ctrl_hold_cs = hold;
    ctrl_frames = 16'(frames); ctrl_soft_rst = srst;
    @(negedge clk);
    ctrl_we = 0; ctrl_soft_rst = 0;
  endtask

  task automatic do_size(int v);
    @(negedge clk); size_we = 1; size_val = 6'(v);
    @(negedge clk); size_we = 0;
  endtask

  task automatic do_div(int v);
    @(negedge clk); div_we = 1; div_val = 8'(v);
    @(negedge clk); div_we = 0;
  endtask

  task automatic clear_mon(int sz);
    exp_size = sz; fi = 0; bi = 0; sin = 0;
    pops = 0; rises = 0; rxn = 0; ovfn = 0; donen = 0; bad_clear = 0;
    hmin = 1000000; hmax = 0; gapmin = 1000000; hi_start = -1000000;
  endtask

  task automatic fill(int n);
    for (int k = 0; k < n; k++) txw[k] = $urandom;
    tx_i = 0; tx_n = n;
  endtask

  // run one transaction; size and divider already configured
  task automatic run_txn(int sz, int dv, int frames, bit hold, bit full);
    int t;
    clear_mon(sz);
    rx_full = full;
    fill(frames);
    do_ctrl(1, hold, frames, 0);
    t = 0;
    while (donen == 0 && t < 30000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk("R6 done pulse seen", donen, 1);
    chk("R4 frames in transaction", pops, frames);
    chk("R11 pops equal frames consumed", tx_i, frames);
    chk("R2 frames seen by slave", fi, frames);
    for (int k = 0; k < frames; k++)
      chk("R2 mosi word", int'(cap[k]), int'(msk(txw[k], sz)));
    if (full) begin
      chk("R8 overflow pulses", ovfn, frames);
      chk("R8 no push while full", rxn, 0);
    end else begin
      chk("R8 no overflow", ovfn, 0);
      chk("R2 received count", rxn, frames);
      for (int k = 0; k < frames; k++)
        chk("R2 miso word", int'(rxq[k]), int'(msk(sword(k), sz)));
    end
    chk("R5 select releases", rises, hold ? 1 : frames);
    if (!hold && frames > 1) chk_ge("R5 select gap", gapmin, 2 * (dv + 1));
    chk("R9 min half period", hmin, dv + 1);
    chk("R9 max half period", hmax, dv + 1);
    chk("R6 done flag", int'(xfer_done), 1);
    chk("R6 ready flag", int'(rx_ready), 1);
    chk("R6 select idle", int'(cs_n), 1);
    chk("R7 flags cleared at frame start", bad_clear, 0);
    rx_full = 0;
    do_ctrl(0, 0, 1, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset cs_n", int'(cs_n), 1);
    chk("R10 reset sclk", int'(sclk), 0);
    chk("R10 reset done flag", int'(xfer_done), 0);
    chk("R10 reset tx_pop", int'(tx_pop), 0);

    // R1: disabled block takes nothing
    clear_mon(4);
    fill(2);
    do_ctrl(0, 0, 2, 0);
    repeat (200) @(negedge clk);
    chk("R1 no pop while disabled", pops, 0);
    chk("R1 cs idle while disabled", int'(cs_n), 1);

    // R1/R4: zero frame count blocks start
    do_ctrl(1, 0, 0, 0);
    repeat (200) @(negedge clk);
    chk("R1 no pop with zero count", pops, 0);
    tx_n = 0;
    do_ctrl(0, 0, 0, 0);
    // R10 defaults from hardware reset: size 4, divider 7
    run_txn(4, 7, 2, 0, 0);

    // R3: rejected size writes
    do_size(12);
    do_size(40);
    do_size(0);
    do_ctrl(1, 0, 0, 0);
    do_size(20);
    do_div(1);
    do_ctrl(0, 0, 0, 0);
    run_txn(12, 1, 2, 0, 0);

    // boundary widths, both modes
    do_size(32); do_div(0);
    run_txn(32, 0, 4, 1, 0);
    do_size(1); do_div(2);
    run_txn(1, 2, 3, 0, 0);
    do_size(1);
    run_txn(1, 2, 3, 1, 0);

    // R8: overflow
    do_size(8); do_div(1);
    run_txn(8, 1, 3, 0, 1);

    // random mix
    for (int n = 0; n < 30; n++) begin
      int sz, dv, fr;
      bit hd;
      sz = 1 + int'($urandom % 32);
      dv = int'($urandom % 4);
      fr = 1 + int'($urandom % 5);
      hd = 1'($urandom % 2);
      do_size(sz); do_div(dv);
      run_txn(sz, dv, fr, hd, 0);
    end

    // R10: soft reset restores defaults
    do_size(16); do_div(2);
    do_ctrl(0, 1, 5, 1);
    @(negedge clk);
    chk("R10 soft reset clears done flag", int'(xfer_done), 0);
    chk("R10 soft reset clears ready flag", int'(rx_ready), 0);
    chk("R10 soft reset select idle", int'(cs_n), 1);
    run_txn(4, 7, 1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule